// File: doc/BRIEF.md
# Camera Parallel Lane Shifter and Byte Packer

This block sits on a parallel camera pixel port, ahead of the capture and processing stage. Every cycle in which the pixel enable is high, it takes one sample from a 12-lane data bus. A 2-bit window select picks which group of upper lanes is kept. The kept bits are moved down to the least-significant output lanes and zero-extended to a 16-bit output word. This lets a narrow sensor, or a deliberate cut from 10 to 8 bits, show up right-aligned downstream.

A 2-bit bridge field can turn on packing. In that mode the low byte of each windowed sample is collected, and two consecutive bytes form one 16-bit word, so a 16-bit-per-pixel source sent as byte pairs over 8 lanes is rebuilt. The bridge field also sets which byte of the pair lands in the low half of the word. A boundary input marks a line or frame edge and puts the pairing back to its first byte.

When the embedded-sync input marks BT.656 operation, packing is forced off whatever the bridge field holds. A dedicated width input then picks an 8-bit or a 10-bit window in place of the window select.

Top module: `cam_lane_packer`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: With packing off, each sample accepted at a clock edge (`pix_valid_i` high) gives exactly one output word, with `out_valid_o` high in the cycle after that edge. A cycle without an accepted sample gives no output.
- R3: The window select works as follows: 00 keeps bits[11:0], 01 keeps bits[11:2], 10 keeps bits[11:4] and 11 keeps bits[11:6]. The kept bits are right-aligned, and every output bit above them is 0.
- R4: Bridge field encoding: 00 and 11 mean packing off, 01 means packing with the first byte in the low half, and 10 means packing with the first byte in the high half.
- R5: With bridge field 01, the byte of each sample is bits[7:0] of its window. The first byte of a pair goes to `out_data_o[7:0]` and the second to `out_data_o[15:8]`.
- R6: With bridge field 10, the halves are swapped: the first byte goes to `out_data_o[15:8]` and the second to `out_data_o[7:0]`.
- R7: While packing, `out_valid_o` is high only in the cycle after every second accepted byte, never after the first byte of a pair.
- R8: While packing, `boundary_i` returns the pairing to the first byte and drops any unpaired byte already held. A sample accepted in the same cycle as `boundary_i` becomes the first byte of a new pair.
- R9: While `embed_sync_i` is 1, packing is off for any bridge field value, and each sample is output on its own as in R2.
- R10: While `embed_sync_i` is 1, the window select is ignored. `embed_wide_i` = 1 keeps bits[11:2] (10-bit), and `embed_wide_i` = 0 keeps bits[11:4] (8-bit).
- R11: With packing off, `boundary_i` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Pixel enable; a sample is accepted when this is high |
| pix_data_i | input | 12 | Raw parallel data lanes |
| shift_sel_i | input | 2 | Window select |
| bridge_sel_i | input | 2 | Packing enable and byte order |
| embed_sync_i | input | 1 | BT.656 embedded-sync mode |
| embed_wide_i | input | 1 | Width in embedded mode: 1 = 10-bit, 0 = 8-bit |
| boundary_i | input | 1 | Line or frame edge; restarts byte pairing |
| out_valid_o | output | 1 | Output word strobe |
| out_data_o | output | 16 | Right-aligned sample or packed word |

## Verification
A wrong pairing phase shows at the ports within two accepted bytes. A word either appears after a lone first byte, or its halves hold bytes from two different pairs, and the scoreboard catches both at the next strobe. A wrong window or mode decode shows on the very next output word, either as a misaligned value or as a word strobe where the reference expects none. A missed boundary clear shows as a word built from the dropped byte at the next pair.

// File: rtl/cam_lane_pkg.sv
package cam_lane_pkg;
  // Bridge field decode; value positions matter to the software that programs them.
  typedef enum logic [1:0] {
    BRG_OFF      = 2'b00,
    BRG_LO_FIRST = 2'b01,
    BRG_HI_FIRST = 2'b10,
    BRG_RSVD     = 2'b11
  } bridge_e;

  // Window select value forced in embedded-sync mode.
  localparam logic [1:0] WIN_10BIT = 2'b01;
  localparam logic [1:0] WIN_8BIT  = 2'b10;
endpackage

// File: rtl/cam_lane_shifter.sv
module cam_lane_shifter #(
  parameter int LANES = 12,
  parameter int STEP  = 2
) (
  input  logic [LANES-1:0] data_i,
  input  logic [1:0]       shift_sel_i,
  input  logic             embed_sync_i,
  input  logic             embed_wide_i,
  output logic [LANES-1:0] win_o
);
  import cam_lane_pkg::*;

  localparam int AMT_W = $clog2(LANES + 1);

  // Number of low lanes dropped for a given window select.
  function automatic logic [AMT_W-1:0] drop_count(input logic [1:0] sel);
    return AMT_W'(int'(sel) * STEP);
  endfunction

  logic [1:0] eff_sel;

  // R10: embedded mode overrides the window select
  always_comb begin
    if (embed_sync_i) eff_sel = embed_wide_i ? WIN_10BIT : WIN_8BIT;
    else              eff_sel = shift_sel_i;
  end

  assign win_o = data_i >> drop_count(eff_sel);
endmodule

// File: rtl/cam_mode_decode.sv
module cam_mode_decode (
  input  logic [1:0] bridge_sel_i,
  input  logic       embed_sync_i,
  output logic       pack_en_o,
  output logic       swap_o
);
  import cam_lane_pkg::*;

  bridge_e brg;
  assign brg = bridge_e'(bridge_sel_i);

  // R4, R9
  always_comb begin
    pack_en_o = 1'b0;
    swap_o    = 1'b0;
    if (!embed_sync_i) begin
      case (brg)
        BRG_LO_FIRST: pack_en_o = 1'b1;
        BRG_HI_FIRST: begin pack_en_o = 1'b1; swap_o = 1'b1; end
        default:      pack_en_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cam_byte_packer.sv
module cam_byte_packer #(
  parameter int LANES  = 12,
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [LANES-1:0]   win_i,
  input  logic               pack_en_i,
  input  logic               swap_i,
  input  logic               boundary_i,
  output logic               valid_o,
  output logic [2*BYTE_W-1:0] word_o,
  output logic               phase_o,
  output logic               pair_done_o
);
  localparam int OUT_W = 2 * BYTE_W;
  localparam int PAD_W = OUT_W - LANES;

  function automatic logic [OUT_W-1:0] zext(input logic [LANES-1:0] w);
    return {{PAD_W{1'b0}}, w};
  endfunction

  function automatic logic [OUT_W-1:0] join_pair(input logic [BYTE_W-1:0] first,
                                                 input logic [BYTE_W-1:0] second,
                                                 input logic swap);
    return swap ? {first, second} : {second, first};
  endfunction

  logic              phase_q;
  logic [BYTE_W-1:0] hold_q;
  logic              valid_q;
  logic [OUT_W-1:0]  word_q;
  logic [BYTE_W-1:0] cur_byte;
  logic              first_slot;

  assign cur_byte    = win_i[BYTE_W-1:0];
  assign first_slot  = boundary_i || !phase_q;
  assign pair_done_o = pack_en_i && valid_i && !first_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!pack_en_i) begin
        phase_q <= 1'b0;
        if (valid_i) begin
          valid_q <= 1'b1;
          word_q  <= zext(win_i);
        end
      end else if (valid_i) begin
        if (first_slot) begin
          hold_q  <= cur_byte;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          valid_q <= 1'b1;
          word_q  <= join_pair(hold_q, cur_byte, swap_i);
        end
      end else if (boundary_i) begin
        phase_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign phase_o = phase_q;

  // R7
  pair_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done_o |=> valid_o);

  // R7
  first_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_en_i && valid_i && first_slot) |=> !valid_o);

  // R8
  boundary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_en_i && boundary_i && !valid_i) |=> !phase_o);
endmodule

// File: rtl/cam_lane_packer.sv
module cam_lane_packer #(
  parameter int LANES  = 12,
  parameter int STEP   = 2,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid_i,
  input  logic [LANES-1:0]    pix_data_i,
  input  logic [1:0]          shift_sel_i,
  input  logic [1:0]          bridge_sel_i,
  input  logic                embed_sync_i,
  input  logic                embed_wide_i,
  input  logic                boundary_i,
  output logic                out_valid_o,
  output logic [2*BYTE_W-1:0] out_data_o
);
  localparam int OUT_W = 2 * BYTE_W;

  logic [LANES-1:0] win;
  logic             pack_en;
  logic             swap;
  logic             phase;
  logic             pair_done;

  cam_lane_shifter #(.LANES(LANES), .STEP(STEP)) u_shift (
    .data_i       (pix_data_i),
    .shift_sel_i  (shift_sel_i),
    .embed_sync_i (embed_sync_i),
    .embed_wide_i (embed_wide_i),
    .win_o        (win)
  );

  cam_mode_decode u_mode (
    .bridge_sel_i (bridge_sel_i),
    .embed_sync_i (embed_sync_i),
    .pack_en_o    (pack_en),
    .swap_o       (swap)
  );

  cam_byte_packer #(.LANES(LANES), .BYTE_W(BYTE_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (pix_valid_i),
    .win_i       (win),
    .pack_en_i   (pack_en),
    .swap_i      (swap),
    .boundary_i  (boundary_i),
    .valid_o     (out_valid_o),
    .word_o      (out_data_o),
    .phase_o     (phase),
    .pair_done_o (pair_done)
  );

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && !pack_en) |=> out_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_i |=> !out_valid_o);

  // R3
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && !pack_en) |=> (out_data_o[OUT_W-1:LANES] == '0));

  // R9
  embed_no_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    embed_sync_i |-> !pack_en);
endmodule

// File: tb/cam_lane_packer_bench.sv
module cam_lane_packer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] data;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [11:0] pix_data_i = '0;
  logic [1:0]  shift_sel_i = '0;
  logic [1:0]  bridge_sel_i = '0;
  logic        embed_sync_i = 1'b0;
  logic        embed_wide_i = 1'b0;
  logic        boundary_i = 1'b0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];
  bit       m_phase = 0;
  logic [7:0] m_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_lane_packer u_cam_lane_packer (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .shift_sel_i(shift_sel_i), .bridge_sel_i(bridge_sel_i), .embed_sync_i(embed_sync_i),
    .embed_wide_i(embed_wide_i), .boundary_i(boundary_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  // Reference window: written as explicit slices per requirement R3 / R10.
  function automatic logic [11:0] ref_win(input logic [11:0] d);
    logic [1:0] s;
    if (embed_sync_i) s = embed_wide_i ? 2'd1 : 2'd2;
    else s = shift_sel_i;
    case (s)
      2'd0: return d;
      2'd1: return {2'b0, d[11:2]};
      2'd2: return {4'b0, d[11:4]};
      default: return {6'b0, d[11:6]};
    endcase
  endfunction

  function automatic bit ref_pack();
    return !embed_sync_i && (bridge_sel_i == 2'b01 || bridge_sel_i == 2'b10);
  endfunction

  task automatic push(input logic [15:0] d, input string req);
    exp_t e;
    e.data = d;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] d, input logic b, input string req);
    logic [11:0] w;
    @(negedge clk);
    pix_valid_i = v;
    pix_data_i = d;
    boundary_i = b;
    w = ref_win(d);
    if (!ref_pack()) begin
      m_phase = 0;
      if (v) push({4'b0, w}, req);
    end else if (v) begin
      if (b || !m_phase) begin
        m_hold = w[7:0];
        m_phase = 1;
      end else begin
        m_phase = 0;
        if (bridge_sel_i == 2'b01) push({w[7:0], m_hold}, req);
        else push({m_hold, w[7:0]}, req);
      end
    end else if (b) m_phase = 0;
  endtask

  task automatic cfg(input logic [1:0] sh, input logic [1:0] br, input logic emb, input logic wide);
    @(negedge clk);
    pix_valid_i = 0;
    shift_sel_i = sh;
    bridge_sel_i = br;
    embed_sync_i = emb;
    embed_wide_i = wide;
    boundary_i = 1;
    m_phase = 0;
  endtask

  task automatic drain(input string req);
    step(0, '0, 0, req);
    step(0, '0, 0, req);
    step(0, '0, 0, req);
    check(sb.size() == 0, req, 16'(sb.size()), 16'h0);
    sb.delete();
  endtask

  // Monitor: scoreboard pop and compare, just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid_o) begin
      if (sb.size() == 0) begin
        check(0, "R7 unexpected word (R2)", out_data_o, 16'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_data_o == e.data, e.req, out_data_o, e.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 0 && out_data_o == 0, "R1 in reset", out_data_o, 16'h0);
    rst_n = 1;
    @(posedge clk); #1;
    check(out_valid_o == 0 && out_data_o == 0, "R1 after reset", {15'b0, out_valid_o}, 16'h0);

    // R2 R3: all four windows, bridge off
    for (int s = 0; s < 4; s++) begin
      cfg(2'(s), 2'b00, 0, 0);
      step(1, 12'hABC, 0, "R3 window");
      step(1, 12'h5F3, 0, "R3 window");
      step(0, 12'hFFF, 0, "R2 idle");
      step(1, 12'hFFF, 0, "R3 window");
      drain("R2 drain");
    end

    // R11: boundary ignored when not packing; R4: code 11 means off
    cfg(2'b00, 2'b11, 0, 0);
    step(1, 12'h123, 1, "R11 boundary bypass");
    step(1, 12'h456, 0, "R4 code11 off");
    step(0, 12'h000, 1, "R11 boundary idle");
    step(1, 12'h789, 1, "R11 boundary bypass");
    drain("R4 drain");

    // R5 R7: low-first packing with gaps
    cfg(2'b00, 2'b01, 0, 0);
    step(1, 12'h011, 0, "R5 pack");
    step(0, 12'h0EE, 0, "R7 gap");
    step(1, 12'h022, 0, "R5 pack");
    step(1, 12'h333, 0, "R5 pack");
    step(1, 12'hF44, 0, "R7 pack");
    drain("R7 drain");

    // R6 with window select 10
    cfg(2'b10, 2'b10, 0, 0);
    step(1, 12'hAB0, 0, "R6 swap");
    step(1, 12'hCD0, 0, "R6 swap");
    step(1, 12'h120, 0, "R6 swap");
    step(0, 12'h000, 0, "R6 gap");
    step(1, 12'h340, 0, "R6 swap");
    drain("R6 drain");

    // R8: boundary alone drops an odd byte; boundary with byte starts new pair
    cfg(2'b00, 2'b01, 0, 0);
    step(1, 12'h0AA, 0, "R8 odd");
    step(0, 12'h000, 1, "R8 boundary");
    step(1, 12'h0B1, 0, "R8 realign");
    step(1, 12'h0B2, 0, "R8 realign");
    step(1, 12'h0C0, 0, "R8 odd");
    step(1, 12'h0D1, 1, "R8 boundary with byte");
    step(1, 12'h0D2, 0, "R8 boundary with byte");
    drain("R8 drain");

    // R9 R10: embedded mode, packing requested but forced off, window select ignored
    cfg(2'b11, 2'b01, 1, 1);
    step(1, 12'hABC, 0, "R10 wide");
    step(1, 12'h3FF, 0, "R9 no pack");
    drain("R9 drain");
    cfg(2'b00, 2'b10, 1, 0);
    step(1, 12'hABC, 0, "R10 narrow");
    step(1, 12'h7E1, 0, "R9 no pack");
    step(1, 12'h0F0, 1, "R9 no pack");
    drain("R10 drain");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule